// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block takes one stream of 24-bit RGB pixels, one pixel per clock, together with a horizontal sync input that marks where each line begins. It steers the pixels onto two 24-bit output ports, A and B. Alongside the data it produces an output data clock and a delayed copy of horizontal sync. Data, clock and sync all leave the block with the same fixed delay, so a receiver can use the data clock and the sync to capture the ports.

In single-port mode every pixel lands on port A and port B is switched off. In dual-port mode pixels alternate between the ports. The first pixel of every line goes to A, and the alternation restarts at each line start, whatever the previous line left behind. Dual-port mode has two timings:

- Paired: both ports change together once per two pixels.
- Alternating: one port changes per pixel.

In both dual timings the output data clock runs at half the pixel rate. Mode inputs are taken only at a line start, so a line never switches mode partway through and a pixel pair is never split.

The steering is done by a state machine with three states. ST_SINGLE routes each pixel to A. ST_WANT_A routes the next pixel to A and moves to ST_WANT_B. ST_WANT_B routes the next pixel to B and moves to ST_WANT_A. A line start overrides the current state:

- If dual mode is selected at that line start, the start pixel goes to A and the machine enters ST_WANT_B.
- Otherwise the machine enters ST_SINGLE.

Reset puts the machine in ST_SINGLE.

Top module: `pixel_demux_dual`

## Requirements
- R1: In single-port mode each pixel is written to port A, port B holds its last value, and `oe_b_o` is 0, which models port B in high impedance.
- R2: In dual-port mode successive pixels of a line are assigned alternately to port A and port B.
- R3: A line start is a cycle in which `hs_i` is 1 and was 0 at the previous clock edge. The pixel of that cycle is assigned to port A, so the alternation restarts on every line, even when the previous line had an odd pixel count.
- R4: In paired dual mode, port A keeps its value on the A-slot pixel. On the following B-slot pixel, port A takes the A-slot pixel and port B takes the B-slot pixel in the same cycle.
- R5: In alternating dual mode, an A-slot pixel updates only port A and a B-slot pixel updates only port B.
- R6: In single-port mode `dclk_o` is the inverted pixel clock: 0 while `clk` is high, 1 while it is low. In dual modes it runs at half rate and rises only at edges where port A does not change:
  - paired mode: it rises on the A-slot output edge and falls on the pair update;
  - alternating mode: it rises on the B-slot output edge.
- R7: A pixel and `hs_i` sampled at rising edge t appear on the ports and on `hs_o` right after edge t+2, a latency of three clocks. In paired mode this latency applies to the B-slot pixel of the pair.
- R8: `dual_i` and `par_i` are sampled only at a line start. A change between line starts has no effect until the next line start.
- R9: While `rst_n` is 0, the ports, `hs_o`, `dclk_o`, `oe_a_o` and `oe_b_o` are all 0. After reset the block is in single-port mode until a line start selects otherwise, and `oe_a_o` is 1 from the first edge on.
- R10: Each pixel carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0, with bit 7 of each field as its MSB. The ports present the fields at the same positions, unaltered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_i | input | 24 | Input pixel, red/green/blue fields |
| hs_i | input | 1 | Horizontal sync; its rising edge marks a line start |
| dual_i | input | 1 | 1 selects dual-port mode (sampled at line start) |
| par_i | input | 1 | In dual mode, 1 selects paired timing and 0 alternating (sampled at line start) |
| port_a_o | output | 24 | Port A data (even pixels in dual mode) |
| port_b_o | output | 24 | Port B data (odd pixels in dual mode) |
| oe_a_o | output | 1 | Port A output enable |
| oe_b_o | output | 1 | Port B output enable, 0 models high impedance |
| dclk_o | output | 1 | Output data clock |
| hs_o | output | 1 | Horizontal sync delayed to match the data |

## Verification
The bench targets these cases:

- A line that ends on an A pixel, followed by a new line. A design that kept its phase across lines would put the new line's first pixel on B.
- `hs_i` held high for two cycles. Treating a level as a start would restart the pairing on the second cycle.
- Mode inputs toggled mid-line. A design that did not wait for the line start would switch timing partway through a pair and corrupt port B.
- A reset in the middle of a dual-mode line. This exposes designs that keep the old mode or leave the enables on.
- The data clock probed in both halves of the pixel clock. An off-by-one in its phase would show as a rising edge on the same edge as a port A change.

// File: rtl/pxdemux_pkg.sv
package pxdemux_pkg;

    // Destination of one pixel after steering
    typedef enum logic [1:0] {
        SLOT_ONLY = 2'd0,   // single-port mode, port A
        SLOT_A    = 2'd1,   // dual mode, even pixel
        SLOT_B    = 2'd2    // dual mode, odd pixel
    } slot_e;

    // Steering state: which port the next mid-line pixel goes to
    typedef enum logic [1:0] {
        ST_SINGLE = 2'd0,
        ST_WANT_A = 2'd1,
        ST_WANT_B = 2'd2
    } steer_state_e;

endpackage

// File: rtl/pxd_capture.sv
module pxd_capture #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_i,
    input  logic             hs_i,
    input  logic             dual_i,
    input  logic             par_i,
    output logic [PIX_W-1:0] s1_pix,
    output logic             s1_hs,
    output logic             s1_start,
    output logic             s1_dual,
    output logic             s1_par
);

    logic hs_last;

    // First register stage: sample inputs, detect line start on the sync rise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_pix   <= '0;
            s1_hs    <= 1'b0;
            s1_start <= 1'b0;
            s1_dual  <= 1'b0;
            s1_par   <= 1'b0;
            hs_last  <= 1'b0;
        end else begin
            s1_pix   <= pix_i;
            s1_hs    <= hs_i;
            s1_start <= hs_i & ~hs_last;
            s1_dual  <= dual_i;
            s1_par   <= par_i;
            hs_last  <= hs_i;
        end
    end

endmodule

// File: rtl/pxd_steer.sv
module pxd_steer
    import pxdemux_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] s1_pix,
    input  logic             s1_hs,
    input  logic             s1_start,
    input  logic             s1_dual,
    input  logic             s1_par,
    output logic [PIX_W-1:0] s2_pix,
    output logic             s2_hs,
    output slot_e            s2_slot,
    output logic             s2_par
);

    steer_state_e state_q, state_d;
    logic         cur_dual, cur_par;
    logic         eff_dual, eff_par;
    slot_e        slot_c;

    // Next-state and slot decision; a line start overrides the running phase
    always_comb begin
        eff_dual = cur_dual;
        eff_par  = cur_par;
        slot_c   = SLOT_ONLY;
        state_d  = state_q;
        if (s1_start) begin
            eff_dual = s1_dual;
            eff_par  = s1_par;
            if (s1_dual) begin
                slot_c  = SLOT_A;
                state_d = ST_WANT_B;
            end else begin
                slot_c  = SLOT_ONLY;
                state_d = ST_SINGLE;
            end
        end else begin
            unique case (state_q)
                ST_SINGLE: begin
                    slot_c  = SLOT_ONLY;
                    state_d = ST_SINGLE;
                end
                ST_WANT_A: begin
                    slot_c  = SLOT_A;
                    state_d = ST_WANT_B;
                end
                ST_WANT_B: begin
                    slot_c  = SLOT_B;
                    state_d = ST_WANT_A;
                end
                default: begin
                    slot_c  = SLOT_ONLY;
                    state_d = ST_SINGLE;
                end
            endcase
        end
    end

    // State register and the mode latched at the line start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_SINGLE;
            cur_dual <= 1'b0;
            cur_par  <= 1'b0;
        end else begin
            state_q  <= state_d;
            cur_dual <= eff_dual;
            cur_par  <= eff_par;
        end
    end

    // Second register stage: carry the pixel with its routing decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_pix  <= '0;
            s2_hs   <= 1'b0;
            s2_slot <= SLOT_ONLY;
            s2_par  <= 1'b0;
        end else begin
            s2_pix  <= s1_pix;
            s2_hs   <= s1_hs;
            s2_slot <= slot_c;
            s2_par  <= eff_par;
        end
    end

    // R2
    alternate_b_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WANT_B && !s1_start) |=> (state_q == ST_WANT_A));

    // R3
    line_start_goes_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_start && s1_dual) |=> (state_q == ST_WANT_B && s2_slot == SLOT_A));

    // R8
    mode_held_midline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_start |=> ($stable(cur_dual) && $stable(cur_par)));

endmodule

// File: rtl/pxd_out.sv
module pxd_out
    import pxdemux_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] s2_pix,
    input  logic             s2_hs,
    input  slot_e            s2_slot,
    input  logic             s2_par,
    output logic [PIX_W-1:0] port_a_o,
    output logic [PIX_W-1:0] port_b_o,
    output logic             oe_a_o,
    output logic             oe_b_o,
    output logic             dclk_o,
    output logic             hs_o
);

    logic [PIX_W-1:0] pend_q;
    logic             single_q;
    logic             dclk_q;
    logic             ld_a_direct, ld_pend, ld_pair, ld_b_direct;

    // Port load strobes from the routing decision
    always_comb begin
        ld_a_direct = (s2_slot == SLOT_ONLY) || (s2_slot == SLOT_A && !s2_par);
        ld_pend     = (s2_slot == SLOT_A) && s2_par;
        ld_pair     = (s2_slot == SLOT_B) && s2_par;
        ld_b_direct = (s2_slot == SLOT_B) && !s2_par;
    end

    // Third register stage: port registers, enables, sync and divided clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_a_o <= '0;
            port_b_o <= '0;
            pend_q   <= '0;
            oe_a_o   <= 1'b0;
            oe_b_o   <= 1'b0;
            hs_o     <= 1'b0;
            single_q <= 1'b0;
            dclk_q   <= 1'b0;
        end else begin
            if (ld_a_direct)
                port_a_o <= s2_pix;
            else if (ld_pair)
                port_a_o <= pend_q;
            if (ld_pair || ld_b_direct)
                port_b_o <= s2_pix;
            if (ld_pend)
                pend_q <= s2_pix;
            oe_a_o   <= 1'b1;
            oe_b_o   <= (s2_slot != SLOT_ONLY);
            hs_o     <= s2_hs;
            single_q <= (s2_slot == SLOT_ONLY);
            unique case (s2_slot)
                SLOT_A:  dclk_q <= s2_par;
                SLOT_B:  dclk_q <= !s2_par;
                default: dclk_q <= 1'b0;
            endcase
        end
    end

    // Pixel-rate clock in single mode, half-rate register in dual mode
    assign dclk_o = single_q ? ~clk : dclk_q;

    // R1
    single_b_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_slot == SLOT_ONLY) |=> (!oe_b_o && $stable(port_b_o)));

    // R4
    pair_holds_on_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_slot == SLOT_A && s2_par) |=> ($stable(port_a_o) && $stable(port_b_o)));

    // R5
    alt_a_keeps_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_slot == SLOT_A && !s2_par) |=> $stable(port_b_o));

    // R6
    dclk_rise_paired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_slot == SLOT_A && s2_par) |=> dclk_q);

endmodule

// File: rtl/pixel_demux_dual.sv
module pixel_demux_dual
    import pxdemux_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int NUM_CH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CH_W*NUM_CH-1:0] pix_i,
    input  logic                   hs_i,
    input  logic                   dual_i,
    input  logic                   par_i,
    output logic [CH_W*NUM_CH-1:0] port_a_o,
    output logic [CH_W*NUM_CH-1:0] port_b_o,
    output logic                   oe_a_o,
    output logic                   oe_b_o,
    output logic                   dclk_o,
    output logic                   hs_o
);

    localparam int PIX_W = CH_W * NUM_CH;

    logic [PIX_W-1:0] s1_pix, s2_pix;
    logic             s1_hs, s1_start, s1_dual, s1_par;
    logic             s2_hs, s2_par;
    slot_e            s2_slot;

    pxd_capture #(.PIX_W(PIX_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_i    (pix_i),
        .hs_i     (hs_i),
        .dual_i   (dual_i),
        .par_i    (par_i),
        .s1_pix   (s1_pix),
        .s1_hs    (s1_hs),
        .s1_start (s1_start),
        .s1_dual  (s1_dual),
        .s1_par   (s1_par)
    );

    pxd_steer #(.PIX_W(PIX_W)) u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_pix   (s1_pix),
        .s1_hs    (s1_hs),
        .s1_start (s1_start),
        .s1_dual  (s1_dual),
        .s1_par   (s1_par),
        .s2_pix   (s2_pix),
        .s2_hs    (s2_hs),
        .s2_slot  (s2_slot),
        .s2_par   (s2_par)
    );

    pxd_out #(.PIX_W(PIX_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .s2_pix   (s2_pix),
        .s2_hs    (s2_hs),
        .s2_slot  (s2_slot),
        .s2_par   (s2_par),
        .port_a_o (port_a_o),
        .port_b_o (port_b_o),
        .oe_a_o   (oe_a_o),
        .oe_b_o   (oe_b_o),
        .dclk_o   (dclk_o),
        .hs_o     (hs_o)
    );

    // Edges seen since reset, saturating, so history-based checks start valid
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            warm_q <= 2'd0;
        else if (warm_q != 2'd3)
            warm_q <= warm_q + 2'd1;
    end

    // R7
    hs_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (hs_o == $past(hs_i, 3)));

    // R9
    oe_a_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q != 2'd0) |-> oe_a_o);

endmodule

// File: tb/pixel_demux_dual_tb.sv
`timescale 1ns/1ps
module pixel_demux_dual_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] pix_i;
    logic        hs_i, dual_i, par_i;
    logic [23:0] port_a_o, port_b_o;
    logic        oe_a_o, oe_b_o, dclk_o, hs_o;

    always #2.5 clk = ~clk;

    pixel_demux_dual u_dut (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .hs_i(hs_i),
        .dual_i(dual_i), .par_i(par_i), .port_a_o(port_a_o),
        .port_b_o(port_b_o), .oe_a_o(oe_a_o), .oe_b_o(oe_b_o),
        .dclk_o(dclk_o), .hs_o(hs_o)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Vector fields: [27]=hs [26]=dual [25]=par [24]=unused [23:0]=pixel
    localparam logic [27:0] VEC [0:31] = '{
        28'h8110000, 28'h0110001, 28'h0110002, 28'h0110003,
        28'h6110004, 28'hE220000, 28'h6220001, 28'h6220002,
        28'h6220003, 28'h6220004, 28'h6220005, 28'h0220006,
        28'hC330000, 28'h4330001, 28'h4330002, 28'h4330003,
        28'h4330004, 28'hC440000, 28'hC440001, 28'h4440002,
        28'hE550000, 28'h6550001, 28'h6550002, 28'h6550003,
        28'h6550004, 28'h8660000, 28'h0660001, 28'h6660002,
        28'h0000000, 28'h0000000, 28'h0000000, 28'h0000000
    };

    // Input history and reference state built from the requirements
    logic        h_hs   [0:1023];
    logic        h_dual [0:1023];
    logic        h_par  [0:1023];
    logic [23:0] h_pix  [0:1023];
    int          ecount;
    logic        m_dual, m_par, m_next_a;
    logic [23:0] e_a, e_b, e_pend;
    logic        e_oeb, e_hs, e_single, e_dq;
    string       e_tag;

    task automatic chk(input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) begin
            h_hs[i] = 0; h_dual[i] = 0; h_par[i] = 0; h_pix[i] = '0;
        end
        ecount = 0;
        m_dual = 0; m_par = 0; m_next_a = 1;
        e_a = '0; e_b = '0; e_pend = '0;
        e_oeb = 0; e_hs = 0; e_single = 0; e_dq = 0;
    endtask

    // Advance the reference by the pixel sampled two edges before this one
    task automatic model_step();
        int          t;
        logic        h, ph, d, p, start, slot_a;
        logic [23:0] px;
        t = ecount - 2;
        h = 0; ph = 0; d = 0; p = 0; px = '0;
        if (t >= 0) begin h = h_hs[t]; d = h_dual[t]; p = h_par[t]; px = h_pix[t]; end
        if (t >= 1) ph = h_hs[t-1];
        start = h && !ph;
        e_tag = "R1";
        if (start) begin
            m_dual = d; m_par = p; m_next_a = 1;
            if (d) e_tag = "R3";
        end else if ((d != m_dual) || (p != m_par)) begin
            e_tag = "R8";
        end
        e_hs = h;
        if (!m_dual) begin
            e_a = px; e_oeb = 0; e_single = 1; e_dq = 0;
        end else begin
            if (e_tag == "R1") e_tag = m_par ? "R4" : "R5";
            slot_a = m_next_a;
            m_next_a = !m_next_a;
            e_oeb = 1; e_single = 0;
            if (m_par) begin
                if (slot_a) e_pend = px; else begin e_a = e_pend; e_b = px; end
                e_dq = slot_a;
            end else begin
                if (slot_a) e_a = px; else e_b = px;
                e_dq = !slot_a;
            end
        end
    endtask

    // Drive one pixel, then check both clock phases after the edge
    task automatic step(input logic h, input logic d, input logic p,
                        input logic [23:0] px);
        hs_i = h; dual_i = d; par_i = p; pix_i = px;
        h_hs[ecount] = h; h_dual[ecount] = d; h_par[ecount] = p; h_pix[ecount] = px;
        @(posedge clk); #1;
        model_step();
        ecount++;
        chk(e_tag, "port_a", port_a_o, e_a);
        chk(e_tag, "port_b", port_b_o, e_b);
        chk("R1", "oe_b", {23'd0, oe_b_o}, {23'd0, e_oeb});
        chk("R9", "oe_a", {23'd0, oe_a_o}, 24'd1);
        chk("R7", "hs_o", {23'd0, hs_o}, {23'd0, e_hs});
        chk("R6", "dclk_high_phase", {23'd0, dclk_o}, {23'd0, (e_single ? 1'b0 : e_dq)});
        @(negedge clk); #1;
        chk("R6", "dclk_low_phase", {23'd0, dclk_o}, {23'd0, (e_single ? 1'b1 : e_dq)});
    endtask

    task automatic check_reset_outputs();
        chk("R9", "rst_port_a", port_a_o, 24'd0);
        chk("R9", "rst_port_b", port_b_o, 24'd0);
        chk("R9", "rst_oe", {22'd0, oe_a_o, oe_b_o}, 24'd0);
        chk("R9", "rst_hs_dclk", {22'd0, hs_o, dclk_o}, 24'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; hs_i = 0; dual_i = 0; par_i = 0; pix_i = '0;
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        check_reset_outputs();                     // R9 reset state
        @(posedge clk); #1;
        chk("R9", "rst_dclk_high", {23'd0, dclk_o}, 24'd0);
        @(negedge clk); #1;
        rst_n = 1;

        // Table walk: single, paired, alternating, held sync, mid-line mode changes
        for (int i = 0; i < 32; i++)
            step(VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][23:0]);

        // R10: field positions pass through unaltered in single mode
        step(1'b1, 1'b0, 1'b0, 24'h80017F);
        step(1'b0, 1'b0, 1'b0, 24'h000000);
        step(1'b0, 1'b0, 1'b0, 24'h000000);
        chk("R10", "red_field", {16'd0, port_a_o[23:16]}, 24'h80);
        chk("R10", "green_field", {16'd0, port_a_o[15:8]}, 24'h01);
        chk("R10", "blue_field", {16'd0, port_a_o[7:0]}, 24'h7F);

        // Reset in the middle of a dual line
        step(1'b1, 1'b1, 1'b0, 24'h770000);
        step(1'b0, 1'b1, 1'b0, 24'h770001);
        step(1'b0, 1'b1, 1'b0, 24'h770002);
        rst_n = 0; #1;
        check_reset_outputs();                     // R9 asynchronous clear
        @(negedge clk); #1;
        model_reset();
        rst_n = 1;
        // R9: back in single mode although dual_i is high mid-line
        for (int i = 0; i < 6; i++)
            step(1'b0, 1'b1, 1'b1, 24'h880000 + 24'(i));
        chk("R9", "single_after_reset_oe_b", {23'd0, oe_b_o}, 24'd0);
        chk("R9", "single_after_reset_port_a", port_a_o, 24'h880003);

        // R3: alternating line with an odd count, then a fresh line starts on A
        step(1'b1, 1'b1, 1'b0, 24'h990000);
        step(1'b0, 1'b1, 1'b0, 24'h990001);
        step(1'b0, 1'b1, 1'b0, 24'h990002);
        step(1'b1, 1'b1, 1'b0, 24'hAA0000);
        step(1'b0, 1'b1, 1'b0, 24'hAA0001);
        step(1'b0, 1'b1, 1'b0, 24'h000000);
        chk("R3", "restart_on_a", port_a_o, 24'hAA0000);
        for (int i = 0; i < 3; i++)
            step(1'b0, 1'b1, 1'b0, 24'h000000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule